// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block turns a fixed-point number held in one binary-point format into the same number held in another format. Each format is a pair of parameters: a count of bits left of the binary point and a count of bits right of it. The binary point always sits between the bit of weight 2^0 and the bit of weight 2^-1. A code `c` with `F` fraction bits therefore stands for the value `c × 2^-F`. One parameter selects whether both formats are unsigned or two's complement. For a signed format, the integer bit count includes the sign bit.

The two parts of the number are handled separately. The fraction part either grows, with zeros appended, or shrinks, where dropped bits are truncated or rounded. The integer part either grows by extension or shrinks. When it shrinks, an out-of-range value is clamped to a limit or has its excess high bits discarded. Two mode inputs choose truncate or round-to-nearest, and saturate or wrap. The result comes with an overflow flag and an inexact flag. The datapath is combinational. A parameter can add one output register stage, which has an asynchronous active-low reset.

Top module: `fx_requant`

## Requirements
- R1: When the output has at least as many fraction bits as the input, the conversion is exact: zeros fill the new low bits, `inexact` stays 0, and neither mode input has any effect on `dout`.
- R2: For unsigned formats, new high bits produced by widening the integer part are zero.
- R3: For signed formats, new high bits produced by widening the integer part are copies of the input sign bit.
- R4: With `round_near` = 0 (truncate), dropped fraction bits are discarded. The result is the floor of the input value on the output grid; for example, signed −1.0625 becomes −1.125 with 3 fraction bits.
- R5: With `round_near` = 1, the result is floor(x + ½ LSB). Exact ties therefore go up: for example, 1.0625 becomes 1.125 and −1.0625 becomes −1.0 with 3 fraction bits. For unsigned values this is round half away from zero.
- R6: Rounding happens before the range check, so a carry out of rounding can by itself cause overflow.
- R7: With `saturate` = 1, an out-of-range result is replaced by a limit. Signed results use maximum 0 followed by all ones, or minimum 1 followed by all zeros when the value is negative. Unsigned results use all ones.
- R8: With `saturate` = 0, an out-of-range result keeps only its low output-width bits, so a signed result may change sign.
- R9: `ovf` is 1 exactly when the value after the fraction step lies outside the output range. This holds in both overflow modes.
- R10: `inexact` is 1 exactly when at least one dropped fraction bit was 1, in both rounding modes.
- R11: With `REG_OUT` = 1, all three outputs appear one clock after the input and are zero while `rst_n` is low. With `REG_OUT` = 0, the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | IN_INT+IN_FRAC | Input code in the input format |
| round_near | input | 1 | 1 = round to nearest (ties up), 0 = truncate |
| saturate | input | 1 | 1 = clamp on overflow, 0 = wrap |
| dout | output | OUT_INT+OUT_FRAC | Output code in the output format |
| ovf | output | 1 | Value did not fit the output range |
| inexact | output | 1 | A nonzero fraction bit was dropped |

## Verification
The hardest case to reach from the ports is an overflow caused only by the rounding carry. It needs an input just below the output maximum whose dropped bits are exactly one half LSB. Random codes almost never produce it. The stimulus therefore places such codes directly, for example 7.9375 into a signed 4.3 output and 15.9375 into an unsigned 4.3 output, under both overflow modes. The same directed phase also applies exact positive and negative ties to confirm the asymmetric signed tie rule, and then a long random sweep over all four mode pairs is compared every cycle against an integer model.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

  typedef enum logic {
    RND_TRUNC   = 1'b0,
    RND_NEAREST = 1'b1
  } rnd_mode_e;

  typedef enum logic {
    OVF_WRAP = 1'b0,
    OVF_SAT  = 1'b1
  } ovf_mode_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fxq_frac_align.sv
module fxq_frac_align #(
  parameter int IN_INT   = 8,
  parameter int IN_FRAC  = 8,
  parameter int OUT_FRAC = 4,
  parameter bit SIGNED   = 1'b1,
  localparam int IN_W    = IN_INT + IN_FRAC,
  localparam int MID_W   = IN_INT + OUT_FRAC + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  din,
  input  logic             rnd_near,
  output logic [MID_W-1:0] mid,
  output logic             inexact
);
  import fxq_pkg::*;

  generate
    if (OUT_FRAC >= IN_FRAC) begin : g_widen
      localparam int SH = OUT_FRAC - IN_FRAC;

      function automatic logic [MID_W-1:0] widen(input logic [IN_W-1:0] v);
        logic [MID_W-1:0] e;
        e = {{(MID_W-IN_W){SIGNED ? v[IN_W-1] : 1'b0}}, v};
        return e << SH;
      endfunction

      assign mid     = widen(din);
      assign inexact = 1'b0;

      // R1: the rounding mode alone never moves the result when widening
      a_r1_mode_blind: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rnd_near) && $stable(din)) |-> $stable(mid));
    end else begin : g_narrow
      localparam int DROP = IN_FRAC - OUT_FRAC;
      localparam int CW   = MID_W + DROP + 1;
      localparam logic signed [CW-1:0] STEP = CW'(1) <<< DROP;
      localparam logic signed [CW-1:0] HALF = STEP >>> 1;

      function automatic logic [MID_W-1:0] requant(input logic [IN_W-1:0] v,
                                                   input rnd_mode_e rm);
        logic [MID_W-1:0] base;
        logic             bump;
        base = {(SIGNED ? v[IN_W-1] : 1'b0), v[IN_W-1:DROP]};
        bump = (rm == RND_NEAREST) && v[DROP-1];
        return base + {{(MID_W-1){1'b0}}, bump};
      endfunction

      function automatic logic lost_any(input logic [IN_W-1:0] v);
        return |v[DROP-1:0];
      endfunction

      assign mid     = requant(din, rnd_mode_e'(rnd_near));
      assign inexact = lost_any(din);

      // Scaled views used only by the checks below
      logic              din_sx, mid_sx;
      logic signed [CW-1:0] din_sc, mid_sc, diff;
      assign din_sx = SIGNED ? din[IN_W-1] : 1'b0;
      assign mid_sx = SIGNED ? mid[MID_W-1] : 1'b0;
      assign din_sc = {{2{din_sx}}, din};
      assign mid_sc = {mid_sx, mid, {DROP{1'b0}}};
      assign diff   = din_sc - mid_sc;

      // R4: truncation lands on the floor of the input value
      a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_near |-> (diff >= 0) && (diff < STEP));
      // R5: rounding stays within half an LSB, ties resolved upward
      a_r5_nearest: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_near |-> (diff >= -HALF) && (diff < HALF));
      // R10: no lost bits means the value is carried exactly
      a_r10_exact: assert property (@(posedge clk) disable iff (!rst_n)
        !inexact |-> (diff == 0));
    end
  endgenerate

endmodule

// File: rtl/fxq_range_fit.sv
module fxq_range_fit #(
  parameter int MID_W  = 9,
  parameter int OUT_W  = 7,
  parameter bit SIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MID_W-1:0] mid,
  input  logic             saturate,
  output logic [OUT_W-1:0] dout,
  output logic             ovf
);
  import fxq_pkg::*;

  localparam int EXT_W = imax(MID_W, OUT_W) + 1;
  localparam logic [OUT_W-1:0] ALL1 = '1;
  localparam logic [OUT_W-1:0] MAXV = SIGNED ? (ALL1 >> 1) : ALL1;
  localparam logic [OUT_W-1:0] MINV = SIGNED ? ~(ALL1 >> 1) : '0;

  function automatic logic [EXT_W-1:0] extend(input logic [MID_W-1:0] v);
    return {{(EXT_W-MID_W){SIGNED ? v[MID_W-1] : 1'b0}}, v};
  endfunction

  function automatic logic in_range(input logic [EXT_W-1:0] e);
    logic [EXT_W-1:0] t;
    if (SIGNED) begin
      t = $unsigned($signed(e) >>> (OUT_W-1));
      return (t == '0) || (t == '1);
    end else begin
      t = e >> OUT_W;
      return t == '0;
    end
  endfunction

  function automatic logic [OUT_W-1:0] pick(input logic [EXT_W-1:0] e,
                                            input logic fits,
                                            input logic neg,
                                            input ovf_mode_e om);
    if (fits || om == OVF_WRAP) return e[OUT_W-1:0];
    return neg ? MINV : MAXV;
  endfunction

  logic [EXT_W-1:0] ext_val;
  logic             fit_ok;
  logic             mid_neg;

  assign ext_val = extend(mid);
  assign fit_ok  = in_range(ext_val);
  assign mid_neg = SIGNED ? mid[MID_W-1] : 1'b0;
  assign ovf     = !fit_ok;
  assign dout    = pick(ext_val, fit_ok, mid_neg, ovf_mode_e'(saturate));

  // R7: clamping on the high side
  a_r7_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (saturate && ovf && !mid_neg) |-> (dout == MAXV));
  // R8: wrap keeps the low bits of the wide value
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !saturate |-> (dout == ext_val[OUT_W-1:0]));
  // R9: a value that fits passes through untouched in either mode
  a_r9_fit_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> (dout == ext_val[OUT_W-1:0]));

  generate
    if (SIGNED) begin : g_neg_chk
      // R7: clamping on the low side for negative values
      a_r7_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (saturate && ovf && mid_neg) |-> (dout == MINV));
    end
  endgenerate

endmodule

// File: rtl/fx_requant.sv
module fx_requant #(
  parameter int IN_INT   = 8,
  parameter int IN_FRAC  = 8,
  parameter int OUT_INT  = 6,
  parameter int OUT_FRAC = 4,
  parameter bit SIGNED   = 1'b1,
  parameter bit REG_OUT  = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IN_INT+IN_FRAC-1:0]   din,
  input  logic                        round_near,
  input  logic                        saturate,
  output logic [OUT_INT+OUT_FRAC-1:0] dout,
  output logic                        ovf,
  output logic                        inexact
);
  localparam int IN_W  = IN_INT + IN_FRAC;
  localparam int OUT_W = OUT_INT + OUT_FRAC;
  localparam int MID_W = IN_INT + OUT_FRAC + 1;

  logic [MID_W-1:0] mid_val;
  logic             frac_inexact;
  logic [OUT_W-1:0] fit_val;
  logic             fit_ovf;

  fxq_frac_align #(
    .IN_INT  (IN_INT),
    .IN_FRAC (IN_FRAC),
    .OUT_FRAC(OUT_FRAC),
    .SIGNED  (SIGNED)
  ) u_frac (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din[IN_W-1:0]),
    .rnd_near(round_near),
    .mid     (mid_val),
    .inexact (frac_inexact)
  );

  fxq_range_fit #(
    .MID_W (MID_W),
    .OUT_W (OUT_W),
    .SIGNED(SIGNED)
  ) u_fit (
    .clk     (clk),
    .rst_n   (rst_n),
    .mid     (mid_val),
    .saturate(saturate),
    .dout    (fit_val),
    .ovf     (fit_ovf)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dout    <= '0;
          ovf     <= 1'b0;
          inexact <= 1'b0;
        end else begin
          dout    <= fit_val;
          ovf     <= fit_ovf;
          inexact <= frac_inexact;
        end
      end

      // R11: one clock from core result to the ports
      a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dout == $past(fit_val)) && (ovf == $past(fit_ovf)));
    end else begin : g_comb
      assign dout    = fit_val;
      assign ovf     = fit_ovf;
      assign inexact = frac_inexact;

      // R11: no hidden state when unregistered
      a_r11_no_state: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(din) && $stable(round_near) && $stable(saturate))
          |-> ($stable(dout) && $stable(ovf) && $stable(inexact)));
    end
  endgenerate

endmodule

// File: tb/tb_fx_requant.sv
module tb_fx_requant;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [11:0] stim = '0;
  logic        rn = 1'b0;
  logic        st = 1'b0;

  logic [6:0]  s_v;  logic s_o,  s_i;
  logic [6:0]  u_v;  logic u_o,  u_i;
  logic [10:0] w_v;  logic w_o,  w_i;
  logic [10:0] uw_v; logic uw_o, uw_i;

  // signed 6.6 -> 4.3, registered
  fx_requant #(.IN_INT(6), .IN_FRAC(6), .OUT_INT(4), .OUT_FRAC(3),
               .SIGNED(1'b1), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .din(stim), .round_near(rn), .saturate(st),
    .dout(s_v), .ovf(s_o), .inexact(s_i));
  // unsigned 6.6 -> 4.3, combinational
  fx_requant #(.IN_INT(6), .IN_FRAC(6), .OUT_INT(4), .OUT_FRAC(3),
               .SIGNED(1'b0), .REG_OUT(1'b0)) dut_u (
    .clk(clk), .rst_n(rst_n), .din(stim), .round_near(rn), .saturate(st),
    .dout(u_v), .ovf(u_o), .inexact(u_i));
  // signed 4.2 -> 6.5, combinational
  fx_requant #(.IN_INT(4), .IN_FRAC(2), .OUT_INT(6), .OUT_FRAC(5),
               .SIGNED(1'b1), .REG_OUT(1'b0)) dut_w (
    .clk(clk), .rst_n(rst_n), .din(stim[5:0]), .round_near(rn), .saturate(st),
    .dout(w_v), .ovf(w_o), .inexact(w_i));
  // unsigned 4.2 -> 6.5, combinational
  fx_requant #(.IN_INT(4), .IN_FRAC(2), .OUT_INT(6), .OUT_FRAC(5),
               .SIGNED(1'b0), .REG_OUT(1'b0)) dut_uw (
    .clk(clk), .rst_n(rst_n), .din(stim[5:0]), .round_near(rn), .saturate(st),
    .dout(uw_v), .ovf(uw_o), .inexact(uw_i));

  int    tests = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_tag = "R11";
  bit    have_prev = 1'b0;
  longint exp_v;
  bit     exp_o, exp_i;

  // Integer model of the requirements: value scaling, floor/round, range
  function automatic longint model(input longint code, input int ii, input int fi,
                                   input int io, input int fo, input bit sg,
                                   input bit rnd, input bit sat,
                                   output bit ov, output bit ix);
    int iw = ii + fi;
    int ow = io + fo;
    longint x, q, r, lo, hi, res;
    x = code & ((64'sd1 <<< iw) - 1);
    if (sg && x[iw-1]) x = x - (64'sd1 <<< iw);
    ix = 1'b0;
    if (fo >= fi) begin
      q = x * (64'sd1 <<< (fo - fi));
    end else begin
      q = x >>> (fi - fo);
      r = x - (q <<< (fi - fo));
      ix = (r != 0);
      if (rnd && r >= (64'sd1 <<< (fi - fo - 1))) q = q + 1;
    end
    lo = sg ? -(64'sd1 <<< (ow - 1)) : 64'sd0;
    hi = sg ? (64'sd1 <<< (ow - 1)) - 1 : (64'sd1 <<< ow) - 1;
    ov = (q < lo) || (q > hi);
    res = q;
    if (ov && sat) res = (q < lo) ? lo : hi;
    return res & ((64'sd1 <<< ow) - 1);
  endfunction

  task automatic chk(input string tag, input string what, input longint got, input longint expv);
    tests++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (stim=%0d rn=%0b st=%0b)",
               tag, what, got, expv, stim, rn, st);
    end
  endtask

  task automatic cmp_comb(input string vtag, input string name, input longint gv,
                          input bit go, input bit gi, input int ii, input int fi,
                          input int io, input int fo, input bit sg);
    longint ev; bit eo, ei;
    ev = model(longint'(stim), ii, fi, io, fo, sg, rn, st, eo, ei);
    chk(vtag, {name, " value"}, gv, ev);
    chk("R9", {name, " ovf"}, longint'(go), longint'(eo));
    chk("R10", {name, " inexact"}, longint'(gi), longint'(ei));
  endtask

  // Apply one input vector at the falling edge; check the registered
  // instance for the previous vector, the combinational ones for this one
  task automatic step(input logic [11:0] v, input bit r, input bit s);
    @(negedge clk);
    if (have_prev) begin
      chk({cur_tag, " R11"}, "reg value", longint'(s_v), exp_v);
      chk("R9", "reg ovf", longint'(s_o), longint'(exp_o));
      chk("R10", "reg inexact", longint'(s_i), longint'(exp_i));
    end
    stim = v; rn = r; st = s;
    #1;
    cmp_comb(cur_tag, "unsigned narrow", longint'(u_v), u_o, u_i, 6, 6, 4, 3, 1'b0);
    cmp_comb("R3", "signed widen", longint'(w_v), w_o, w_i, 4, 2, 6, 5, 1'b1);
    cmp_comb("R2", "unsigned widen", longint'(uw_v), uw_o, uw_i, 4, 2, 6, 5, 1'b0);
    exp_v = model(longint'(v), 6, 6, 4, 3, 1'b1, r, s, exp_o, exp_i);
    have_prev = 1'b1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    longint ref_w, ref_uw;
    repeat (3) @(negedge clk);
    // R11: reset state of the registered outputs
    chk("R11", "reset value", longint'(s_v), 0);
    chk("R11", "reset ovf", longint'(s_o), 0);
    chk("R11", "reset inexact", longint'(s_i), 0);
    rst_n = 1'b1;

    cur_tag = "R11";
    step(12'd0, 1'b1, 1'b1);
    after_edge();
    // R11: new input not visible before the clock edge
    step(12'd68, 1'b1, 1'b1);
    chk("R11", "latency hold", longint'(s_v), 0);
    after_edge();
    cur_tag = "R5";
    chk("R5", "positive tie 1.0625", longint'(s_v), 9);
    chk("R5", "unsigned tie 1.0625", longint'(u_v), 9);
    chk("R10", "tie inexact", longint'(s_i), 1);

    step(12'd4028, 1'b1, 1'b1);
    after_edge();
    chk("R5", "negative tie -1.0625", longint'(s_v), 120);

    cur_tag = "R4";
    step(12'd4028, 1'b0, 1'b1);
    after_edge();
    chk("R4", "truncate -1.0625", longint'(s_v), 119);
    step(12'd68, 1'b0, 1'b1);
    chk("R4", "unsigned truncate 1.0625", longint'(u_v), 8);

    cur_tag = "R6";
    step(12'd508, 1'b1, 1'b1);
    after_edge();
    chk("R6", "carry saturates", longint'(s_v), 63);
    chk("R6", "carry ovf", longint'(s_o), 1);
    step(12'd1020, 1'b1, 1'b1);
    chk("R6", "unsigned carry saturates", longint'(u_v), 127);
    chk("R6", "unsigned carry ovf", longint'(u_o), 1);

    cur_tag = "R8";
    step(12'd508, 1'b1, 1'b0);
    after_edge();
    chk("R8", "carry wraps to negative", longint'(s_v), 64);
    chk("R9", "wrap still flags", longint'(s_o), 1);
    step(12'd1020, 1'b1, 1'b0);
    chk("R8", "unsigned wrap", longint'(u_v), 0);

    cur_tag = "R7";
    step(12'd2048, 1'b0, 1'b1);
    after_edge();
    chk("R7", "negative clamp", longint'(s_v), 64);
    step(12'd2047, 1'b0, 1'b1);
    after_edge();
    chk("R7", "positive clamp", longint'(s_v), 63);

    cur_tag = "R10";
    step(12'd64, 1'b1, 1'b1);
    chk("R10", "exact input", longint'(u_i), 0);
    step(12'd65, 1'b0, 1'b1);
    chk("R10", "one lost bit", longint'(u_i), 1);

    // R1: widening ignores both modes
    cur_tag = "R1";
    for (int k = 0; k < 6; k++) begin
      step(12'(k * 11 + 37), 1'b0, 1'b0);
      ref_w = longint'(w_v);
      ref_uw = longint'(uw_v);
      for (int m = 1; m < 4; m++) begin
        step(12'(k * 11 + 37), m[0], m[1]);
        chk("R1", "signed widen mode blind", longint'(w_v), ref_w);
        chk("R1", "unsigned widen mode blind", longint'(uw_v), ref_uw);
        chk("R1", "widen exact", longint'(w_i), 0);
      end
    end

    for (int n = 0; n < 3000; n++) begin
      logic [11:0] v;
      bit r, s;
      v = 12'($urandom);
      r = 1'($urandom);
      s = 1'($urandom);
      if (n % 7 == 0) v = {v[11:3], 3'b100};
      cur_tag = $sformatf("%s/%s", r ? "R5" : "R4", s ? "R7" : "R8");
      step(v, r, s);
    end

    @(negedge clk);
    chk({cur_tag, " R11"}, "reg value", longint'(s_v), exp_v);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule